// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns level changes on a 32-pin general-purpose I/O port into interrupts. Every pin is synchronised to the core clock, and edges are found by comparing each synchronised level with its value one clock earlier. Each pin has its own rising-edge enable and falling-edge enable. Software changes an enable only through a write-one-to-set register or a write-one-to-clear register, so no read-modify-write sequence is needed. An enabled edge latches a bit in a status register. Software clears that bit by writing a one to it.

The status bits are grouped into banks of 16 pins. Each bank drives one level-sensitive summary interrupt line, and a per-bank enable register gates that line. A parameterised number of the lowest pins also drive direct interrupt outputs. Each direct output gives a one-clock pulse per enabled edge. These direct outputs use the same edge-enable settings as the status register.

Top module: `gpio_edge_irq`

## Requirements
- R1: Writing word address 0 sets the rising-edge enable of every pin whose data bit is 1, and address 1 clears those bits. Address 2 sets the falling-edge enables and address 3 clears them. Bits written as 0 are untouched. The current rising and falling enables read back at addresses 5 and 6. Addresses 0 to 3 read as zero.
- R2: A pin with both enables set records an event on either edge. A pin with only one enable set records an event only on that edge.
- R3: The status register at address 4 latches each enabled edge event. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: Bank b's summary output is the OR of status bits b*16 to b*16+15, gated by the bank enable.
- R5: The bank-enable register at word address 8 holds bit b for bank b and reads back at the same address. While bit b is 0, summary output b is low whatever the status.
- R6: Pins 0 to N_DIRECT-1 drive direct outputs. Each direct output is high for exactly the one clock in which its status bit gets set by an edge.
- R7: After reset, all edge enables, all status bits and all bank enables are zero, so no output is asserted.
- R8: A pin change applied before clock edge k is recorded in status and on the direct output after edge k+2. The pin passes two synchroniser stages and is then compared with its previous level.
- R9: When a new edge and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | N_PINS | Write data |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | N_PINS | Combinational read data |
| bank_irq_o | output | N_BANKS | Per-bank summary interrupt levels |
| direct_irq_o | output | N_DIRECT | Per-pin direct interrupt pulses |

## Verification
The bench aims a clear write at a status bit in the same cycle that a fresh edge lands on it. A design that lets the clear win would lose that interrupt. It writes zeros to the status register and checks that nothing changes, which catches a design that loads the write data instead of treating it as a clear mask. It disables a bank that holds pending status and checks that the summary line drops. It also fires one edge and checks that the direct output is high for exactly one clock, which catches a design that latches the pulse or ignores the enables. Random pin activity, mixed with random register writes, is compared every cycle with a bench model of the synchroniser and the registers, so an error of even one cycle in the latency is reported.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int N_PINS   = 32,
  parameter int BANK_W   = 16,
  parameter int N_DIRECT = 4,
  parameter int AW       = 4,
  localparam int N_BANKS = (N_PINS + BANK_W - 1) / BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PINS-1:0]   pin_i,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [N_PINS-1:0]   wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [N_PINS-1:0]   rd_data,
  output logic [N_BANKS-1:0]  bank_irq_o,
  output logic [N_DIRECT-1:0] direct_irq_o
);
  localparam logic [AW-1:0] A_RSET = AW'(0);
  localparam logic [AW-1:0] A_RCLR = AW'(1);
  localparam logic [AW-1:0] A_FSET = AW'(2);
  localparam logic [AW-1:0] A_FCLR = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_REN  = AW'(5);
  localparam logic [AW-1:0] A_FEN  = AW'(6);
  localparam logic [AW-1:0] A_BEN  = AW'(8);

  logic [N_PINS-1:0]   sy1, sy2, prv;
  logic [N_PINS-1:0]   ren_q, fen_q, stat_q;
  logic [N_BANKS-1:0]  ben_q;
  logic [N_DIRECT-1:0] dir_q;
  logic [N_PINS-1:0]   ev, clr_mask;

  assign ev       = (sy2 & ~prv & ren_q) | (~sy2 & prv & fen_q);
  assign clr_mask = (wr_en && wr_addr == A_STAT) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1 <= '0; sy2 <= '0; prv <= '0;
      ren_q <= '0; fen_q <= '0; stat_q <= '0;
      ben_q <= '0; dir_q <= '0;
    end else begin
      sy1    <= pin_i;
      sy2    <= sy1;
      prv    <= sy2;
      stat_q <= (stat_q & ~clr_mask) | ev;
      dir_q  <= ev[N_DIRECT-1:0];
      if (wr_en) begin
        case (wr_addr)
          A_RSET:  ren_q <= ren_q | wr_data;
          A_RCLR:  ren_q <= ren_q & ~wr_data;
          A_FSET:  fen_q <= fen_q | wr_data;
          A_FCLR:  fen_q <= fen_q & ~wr_data;
          A_BEN:   ben_q <= wr_data[N_BANKS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = stat_q;
      A_REN:   rd_data = ren_q;
      A_FEN:   rd_data = fen_q;
      A_BEN:   rd_data = {{(N_PINS-N_BANKS){1'b0}}, ben_q};
      default: rd_data = '0;
    endcase
  end

  assign direct_irq_o = dir_q;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    localparam int HI = (LO + BANK_W > N_PINS) ? N_PINS - 1 : LO + BANK_W - 1;
    assign bank_irq_o[b] = ben_q[b] & (|stat_q[HI:LO]);

    AST_BANK_GATED: assert property (@(posedge clk) disable iff (rst)
      bank_irq_o[b] |-> (ben_q[b] && stat_q[HI:LO] != '0)); // R5
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ren_q == '0 && fen_q == '0 && stat_q == '0 && ben_q == '0)); // R7

  AST_ONLY_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(stat_q) & ~stat_q & ~$past(clr_mask)) == '0)); // R3

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(ev) & ~stat_q) == '0)); // R9

  AST_DIRECT_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
    ((direct_irq_o & ~stat_q[N_DIRECT-1:0]) == '0)); // R6
endmodule

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32, NB = 2, ND = 4, AW = 4;

  logic clk = 0, rst = 1;
  logic [NP-1:0] pins = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = 4'd4;
  logic [NP-1:0] wr_data = '0;
  logic [NP-1:0] rd_data;
  logic [NB-1:0] bank_irq;
  logic [ND-1:0] direct_irq;

  int tests = 0, fails = 0;

  gpio_edge_irq dut (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bank_irq_o(bank_irq), .direct_irq_o(direct_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model built from the requirements
  logic [NP-1:0] m_s1, m_s, m_p, m_ren, m_fen, m_stat, m_ev;
  logic [NB-1:0] m_ben;
  logic [ND-1:0] m_dir;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s = '0; m_p = '0; m_ren = '0; m_fen = '0;
      m_stat = '0; m_ben = '0; m_dir = '0;
    end else begin
      m_ev = (m_s & ~m_p & m_ren) | (~m_s & m_p & m_fen);
      m_dir = m_ev[ND-1:0];
      m_stat = (m_stat & ~((wr_en && wr_addr == 4'd4) ? wr_data : '0)) | m_ev;
      if (wr_en) begin
        case (wr_addr)
          4'd0: m_ren = m_ren | wr_data;
          4'd1: m_ren = m_ren & ~wr_data;
          4'd2: m_fen = m_fen | wr_data;
          4'd3: m_fen = m_fen & ~wr_data;
          4'd8: m_ben = wr_data[NB-1:0];
          default: ;
        endcase
      end
      m_p = m_s; m_s = m_s1; m_s1 = pins;
    end
  end

  function automatic logic [NP-1:0] exp_rd(input logic [AW-1:0] a);
    case (a)
      4'd4: return m_stat;
      4'd5: return m_ren;
      4'd6: return m_fen;
      4'd8: return {{(NP-NB){1'b0}}, m_ben};
      default: return '0;
    endcase
  endfunction

  function automatic logic [NB-1:0] exp_bank();
    logic [NB-1:0] r;
    r[0] = m_ben[0] & (|m_stat[15:0]);
    r[1] = m_ben[1] & (|m_stat[31:16]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // at a falling edge: compare outputs with the model, then leave inputs idle
  task automatic cyc(input string tag);
    @(negedge clk);
    chk(rd_data == exp_rd(rd_addr), {tag, " rd_data"}, rd_data, exp_rd(rd_addr));
    chk(bank_irq == exp_bank(), {tag, " bank_irq R4"}, NP'(bank_irq), NP'(exp_bank()));
    chk(direct_irq == m_dir, {tag, " direct R6"}, NP'(direct_irq), NP'(m_dir));
    wr_en = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d, input string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R7 reset state
    rd_addr = 4'd5; cyc("R7 ren");
    chk(rd_data == '0, "R7 rising enables zero", rd_data, '0);
    rd_addr = 4'd6; cyc("R7 fen");
    chk(rd_data == '0, "R7 falling enables zero", rd_data, '0);
    rd_addr = 4'd8; cyc("R7 ben");
    rd_addr = 4'd4;
    pins = '1; repeat (4) cyc("R7 no enable");
    chk(rd_data == '0, "R7 edge without enable ignored", rd_data, '0);
    pins = '0; repeat (4) cyc("R7 settle");

    // R1 set/clear registers
    wr(4'd0, 32'h0000_0005, "R1 rset");
    wr(4'd2, 32'h0001_0004, "R1 fset");
    wr(4'd1, 32'h0000_0004, "R1 rclr");
    rd_addr = 4'd5; cyc("R1 read ren");
    chk(rd_data == 32'h1, "R1 rising enables", rd_data, 32'h1);
    rd_addr = 4'd6; cyc("R1 read fen");
    chk(rd_data == 32'h0001_0004, "R1 falling enables", rd_data, 32'h0001_0004);
    rd_addr = 4'd0; cyc("R1 write-only reads zero");
    rd_addr = 4'd4;
    wr(4'd8, 32'h3, "R5 ben");

    // R8/R6 latency and pulse width on pin 0 rising
    pins[0] = 1;
    cyc("R8 k"); cyc("R8 k+1");
    chk(direct_irq[0] == 0, "R8 not yet", NP'(direct_irq), '0);
    cyc("R8 k+2");
    chk(direct_irq[0] == 1 && rd_data[0], "R8/R6 recorded", rd_data, 32'h1);
    cyc("R6 pulse end");
    chk(direct_irq[0] == 0, "R6 one clock pulse", NP'(direct_irq), '0);
    // falling on pin 0 not enabled
    pins[0] = 0; repeat (4) cyc("R2 fall ignored");
    chk(m_dir == 0 && direct_irq == 0, "R2 single polarity", NP'(direct_irq), '0);

    // R3 write zero no effect
    wr(4'd4, 32'h0, "R3 w0");
    chk(rd_data[0] == 1, "R3 write zero keeps bit", rd_data, 32'h1);
    // R5 bank gating
    wr(4'd8, 32'h0, "R5 ben off");
    chk(bank_irq == 0, "R5 bank disabled", NP'(bank_irq), '0);
    wr(4'd8, 32'h3, "R5 ben on");
    chk(bank_irq[0] == 1, "R4 bank0 summary", NP'(bank_irq), 32'h1);

    // R9 collision on pin 0: status bit 0 already set
    pins[0] = 1;
    cyc("R9 a"); cyc("R9 b");
    wr(4'd4, 32'h1, "R9 clear and edge");
    chk(rd_data[0] == 1, "R9 new edge wins", rd_data, 32'h1);
    wr(4'd4, 32'h1, "R3 clear");
    chk(rd_data[0] == 0, "R3 write one clears", rd_data, '0);

    // R2 both edges on pin 16
    wr(4'd0, 32'h0001_0000, "R2 rset16");
    pins[16] = 1; repeat (4) cyc("R2 rise");
    wr(4'd4, 32'h0001_0000, "R2 clr");
    chk(rd_data[16] == 0, "R2 cleared", rd_data, '0);
    pins[16] = 0; repeat (4) cyc("R2 fall");
    chk(rd_data[16] == 1 && bank_irq[1], "R2 falling also fires", rd_data, 32'h0001_0000);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      pins = pins ^ ($urandom & $urandom);
      if ($urandom_range(3) == 0) begin
        rd_addr = AW'($urandom_range(8));
        wr_en = 1; wr_addr = AW'($urandom_range(8)); wr_data = $urandom;
      end
      cyc("R1/R2/R3/R4/R5/R9 random");
      rd_addr = 4'd4;
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule